// File: doc/BRIEF.md
# Advanced Load Address Table

This block tracks loads that a scheduler has hoisted above stores whose addresses were unknown at compile time. Each hoisted load records its destination register number, the low bits of its physical address and its access width. Every retiring store is snooped against all live records. Any record whose byte range overlaps the store's byte range is dropped. Later, at the load's original program position, a check names the destination register. A surviving record means the early data is still correct. A missing record means the pipeline must issue the load again.

Records are kept per destination register, not per address. A register owns at most one record at a time. A context switch wipes the whole table in a single cycle and saves nothing. When every slot is occupied, a round-robin pointer picks the record to discard. Losing a record this way is always safe, because its only effect is an extra reload.

A small controller with two states, `ST_RUN` and `ST_STALL`, holds back consumers of a register whose check missed. The transition `ST_RUN -> ST_STALL` is taken when a check misses. The transition `ST_STALL -> ST_RUN` is taken when the reload is reported done and no new check misses in that same cycle. In every other case the controller stays in its current state.

Top module: `alat_table`

## Requirements
- R1: After reset every slot is empty, `chk_valid_o`, `chk_hit_o` and `stall_o` are low, and a first check misses.
- R2: A check of a register that has a live record returns `chk_valid_o`=1 and `chk_hit_o`=1 one cycle after the check request.
- R3: Inserting a register that already owns a record replaces that record. The old address no longer matters, and a register never owns two records.
- R4: Access size is a 2-bit code giving 1<<code bytes (0=1, 1=2, 2=4, 3=8). A store removes every record whose byte range shares at least one byte with the store's byte range. Adjacent ranges that do not touch leave the record alive.
- R5: A check with `ck_clr_i` set reports the lookup result and then removes the matched record, so a repeat check misses.
- R6: `flush_i` empties the whole table in one cycle. An insert presented in that same cycle is dropped, and a check in that cycle misses.
- R7: A miss raises `stall_o` in the same cycle the miss result appears. `stall_o` stays high until `reload_done_i` is seen, and a hit never raises it. `reload_done_i` has no effect while not stalled.
- R8: When a store and a check arrive in the same cycle, the store's removal is applied before the check result is formed.
- R9: The table holds ENTRIES records (8 by default). An insert takes a free slot first. When no slot is free, it replaces the slot at a round-robin pointer that starts at slot 0 and advances by one after each forced replacement.
- R10: Only address bits [TAG_W-1:0] (20 by default) are compared, with modular wrap. Addresses that differ only above the tag therefore collide, and ranges that cross the top of the tag space wrap to zero.
- R11: A check in the same cycle as an insert of the same register sees the table as it was before that insert.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Context switch: clear all records |
| ld_req_i | input | 1 | Advanced load insert request |
| ld_reg_i | input | REG_W | Destination register of the load |
| ld_addr_i | input | ADDR_W | Physical address of the load |
| ld_size_i | input | 2 | Load size code |
| st_req_i | input | 1 | Store snoop request |
| st_addr_i | input | ADDR_W | Physical address of the store |
| st_size_i | input | 2 | Store size code |
| ck_req_i | input | 1 | Check request |
| ck_clr_i | input | 1 | Remove the matched record after the check |
| ck_reg_i | input | REG_W | Register being checked |
| reload_done_i | input | 1 | The reissued load has completed |
| chk_valid_o | output | 1 | Check result valid (one cycle after request) |
| chk_hit_o | output | 1 | Check hit: early data still good |
| stall_o | output | 1 | Hold consumers of the missed register |

## Verification
The bench builds the block with its default parameters: 8 entries, 7-bit register numbers, 32-bit addresses and a 20-bit tag. With eight slots, a full table followed by a ninth and tenth insert is reachable in a few cycles, which exposes the round-robin victim order and the preference for free slots. The 20-bit tag lets the bench place addresses that differ only in bit 20 and ranges that straddle the wrap point at 0xFFFFF. A sweep over all sixteen load/store size pairs and store offsets from -12 to +12 bytes compares every snoop outcome against a range overlap computed arithmetically in the bench.

// File: rtl/alat_pkg.sv
package alat_pkg;
    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_STALL = 1'b1
    } stall_state_e;
endpackage

// File: rtl/alat_entry.sv
module alat_entry
    import alat_pkg::*;
#(
    parameter int REG_W = 7,
    parameter int TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             ins_req_i,
    input  logic             ins_we_i,
    input  logic [REG_W-1:0] ins_reg_i,
    input  logic [TAG_W-1:0] ins_tag_i,
    input  acc_size_e        ins_size_i,
    input  logic             st_req_i,
    input  logic [TAG_W-1:0] st_tag_i,
    input  acc_size_e        st_size_i,
    input  logic             ck_req_i,
    input  logic             ck_clr_i,
    input  logic [REG_W-1:0] ck_reg_i,
    output logic             valid_o,
    output logic             same_reg_o,
    output logic             ck_live_o
);
    logic             valid_q;
    logic [REG_W-1:0] reg_q;
    logic [TAG_W-1:0] tag_q;
    acc_size_e        size_q;

    logic [TAG_W-1:0] own_bytes, st_bytes, fwd_gap, back_gap;
    logic             overlap, st_kill, ck_match, clr_kill;

    always_comb begin
        own_bytes  = TAG_W'(1) << size_q;
        st_bytes   = TAG_W'(1) << st_size_i;
        fwd_gap    = st_tag_i - tag_q;
        back_gap   = tag_q - st_tag_i;
        overlap    = (fwd_gap < own_bytes) || (back_gap < st_bytes);
        st_kill    = valid_q && st_req_i && overlap;
        ck_match   = valid_q && ck_req_i && (reg_q == ck_reg_i);
        clr_kill   = ck_match && ck_clr_i;
        ck_live_o  = ck_match && !st_kill;
        same_reg_o = valid_q && ins_req_i && (reg_q == ins_reg_i);
        valid_o    = valid_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            reg_q   <= '0;
            tag_q   <= '0;
            size_q  <= SZ_B1;
        end else if (flush_i) begin
            valid_q <= 1'b0;
        end else if (ins_we_i) begin
            valid_q <= 1'b1;
            reg_q   <= ins_reg_i;
            tag_q   <= ins_tag_i;
            size_q  <= ins_size_i;
        end else if (st_kill || clr_kill || same_reg_o) begin
            valid_q <= 1'b0;
        end
    end

    // R4: an overlapping store leaves this slot empty on the next cycle
    p_store_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_kill && !ins_we_i) |=> !valid_q);

    // R5: a clearing check empties the matched slot
    p_check_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_kill && !ins_we_i) |=> !valid_q);
endmodule

// File: rtl/alat_victim.sv
module alat_victim #(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic               ins_req_i,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [ENTRIES-1:0] same_reg_i,
    output logic [ENTRIES-1:0] sel_o
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_q;
    logic             use_rr;
    logic             found;

    always_comb begin
        sel_o  = '0;
        use_rr = 1'b0;
        found  = 1'b0;
        if (ins_req_i && !flush_i) begin
            if (|same_reg_i) begin
                sel_o = same_reg_i;
            end else if (!(&valid_i)) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (!found && !valid_i[i]) begin
                        sel_o[i] = 1'b1;
                        found    = 1'b1;
                    end
                end
            end else begin
                sel_o[rr_q] = 1'b1;
                use_rr      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rr_q <= '0;
        else if (use_rr)
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end

    // R9: an accepted insert lands in exactly one slot
    p_one_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req_i && !flush_i) |-> ($countones(sel_o) == 1));
endmodule

// File: rtl/alat_stall_fsm.sv
module alat_stall_fsm
    import alat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic miss_now_i,
    input  logic reload_done_i,
    output logic stall_o
);
    stall_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   state_d = miss_now_i ? ST_STALL : ST_RUN;
            ST_STALL: state_d = (reload_done_i && !miss_now_i) ? ST_RUN : ST_STALL;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb stall_o = (state_q == ST_STALL);

    // R7: the stall only ends on a reported reload
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !reload_done_i) |=> stall_o);
endmodule

// File: rtl/alat_table.sv
module alat_table
    import alat_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int REG_W   = 7,
    parameter int ADDR_W  = 32,
    parameter int TAG_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              ld_req_i,
    input  logic [REG_W-1:0]  ld_reg_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic [1:0]        ld_size_i,
    input  logic              st_req_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic [1:0]        st_size_i,
    input  logic              ck_req_i,
    input  logic              ck_clr_i,
    input  logic [REG_W-1:0]  ck_reg_i,
    input  logic              reload_done_i,
    output logic              chk_valid_o,
    output logic              chk_hit_o,
    output logic              stall_o
);
    logic [ENTRIES-1:0] valid_vec, same_vec, live_vec, sel_vec;
    logic               hit_now, miss_now;
    logic               chk_valid_q, chk_hit_q;
    logic               unused_hi_addr;

    assign unused_hi_addr = ^{ld_addr_i[ADDR_W-1:TAG_W], st_addr_i[ADDR_W-1:TAG_W]};

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        alat_entry #(.REG_W(REG_W), .TAG_W(TAG_W)) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush_i    (flush_i),
            .ins_req_i  (ld_req_i),
            .ins_we_i   (sel_vec[g]),
            .ins_reg_i  (ld_reg_i),
            .ins_tag_i  (ld_addr_i[TAG_W-1:0]),
            .ins_size_i (acc_size_e'(ld_size_i)),
            .st_req_i   (st_req_i),
            .st_tag_i   (st_addr_i[TAG_W-1:0]),
            .st_size_i  (acc_size_e'(st_size_i)),
            .ck_req_i   (ck_req_i),
            .ck_clr_i   (ck_clr_i),
            .ck_reg_i   (ck_reg_i),
            .valid_o    (valid_vec[g]),
            .same_reg_o (same_vec[g]),
            .ck_live_o  (live_vec[g])
        );
    end

    alat_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .ins_req_i  (ld_req_i),
        .valid_i    (valid_vec),
        .same_reg_i (same_vec),
        .sel_o      (sel_vec)
    );

    always_comb begin
        hit_now  = ck_req_i && (|live_vec) && !flush_i;
        miss_now = ck_req_i && !hit_now;
    end

    alat_stall_fsm u_stall (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_now_i    (miss_now),
        .reload_done_i (reload_done_i),
        .stall_o       (stall_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_valid_q <= 1'b0;
            chk_hit_q   <= 1'b0;
        end else begin
            chk_valid_q <= ck_req_i;
            chk_hit_q   <= hit_now;
        end
    end

    assign chk_valid_o = chk_valid_q;
    assign chk_hit_o   = chk_hit_q;

    // R3: a register owns at most one record
    p_unique_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req_i |-> $onehot0(same_vec));

    // R6: a context switch leaves the table empty
    p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_vec == '0));

    // R7: a reported miss is always accompanied by a stall
    p_miss_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid_o && !chk_hit_o) |-> stall_o);

    // R2: a hit only appears as the answer to a check
    p_hit_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_hit_o |-> chk_valid_o);
endmodule

// File: tb/tb_alat_table.sv
module tb_alat_table;
    localparam int REG_W  = 7;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              flush_i, ld_req_i, st_req_i, ck_req_i, ck_clr_i, reload_done_i;
    logic [REG_W-1:0]  ld_reg_i, ck_reg_i;
    logic [ADDR_W-1:0] ld_addr_i, st_addr_i;
    logic [1:0]        ld_size_i, st_size_i;
    logic              chk_valid_o, chk_hit_o, stall_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    alat_table dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .ld_req_i(ld_req_i), .ld_reg_i(ld_reg_i), .ld_addr_i(ld_addr_i), .ld_size_i(ld_size_i),
        .st_req_i(st_req_i), .st_addr_i(st_addr_i), .st_size_i(st_size_i),
        .ck_req_i(ck_req_i), .ck_clr_i(ck_clr_i), .ck_reg_i(ck_reg_i),
        .reload_done_i(reload_done_i),
        .chk_valid_o(chk_valid_o), .chk_hit_o(chk_hit_o), .stall_o(stall_o)
    );

    task automatic cmp(input logic act, input logic exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        flush_i = 0; ld_req_i = 0; st_req_i = 0; ck_req_i = 0; ck_clr_i = 0; reload_done_i = 0;
    endtask

    task automatic insert(input int r, input int a, input int sz);
        ld_req_i = 1; ld_reg_i = REG_W'(r); ld_addr_i = ADDR_W'(a); ld_size_i = 2'(sz);
        tick(); quiet();
    endtask

    task automatic store(input int a, input int sz);
        st_req_i = 1; st_addr_i = ADDR_W'(a); st_size_i = 2'(sz);
        tick(); quiet();
    endtask

    task automatic release_stall();
        if (stall_o) begin
            reload_done_i = 1; tick(); quiet();
        end
    endtask

    // check a register, compare the result, clear any stall afterwards
    task automatic check(input int r, input logic clr, input logic exp, input string req);
        ck_req_i = 1; ck_clr_i = clr; ck_reg_i = REG_W'(r);
        tick(); quiet();
        cmp(chk_valid_o, 1'b1, req);
        cmp(chk_hit_o, exp, req);
        release_stall();
    endtask

    task automatic flush();
        flush_i = 1; tick(); quiet();
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; quiet();
        ld_reg_i = '0; ck_reg_i = '0; ld_addr_i = '0; st_addr_i = '0; ld_size_i = '0; st_size_i = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        cmp(chk_valid_o, 1'b0, "R1"); cmp(chk_hit_o, 1'b0, "R1"); cmp(stall_o, 1'b0, "R1");
        rst_n = 1;
        tick();
        // R7: reload_done while running has no effect
        reload_done_i = 1; tick(); quiet();
        cmp(stall_o, 1'b0, "R7");
        // R1 / R7: first check misses and stalls until reload done
        ck_req_i = 1; ck_reg_i = 0; tick(); quiet();
        cmp(chk_hit_o, 1'b0, "R1"); cmp(stall_o, 1'b1, "R7");
        tick(); cmp(stall_o, 1'b1, "R7");
        reload_done_i = 1; tick(); quiet();
        cmp(stall_o, 1'b0, "R7");

        // R2: insert then hit, no stall
        insert(3, 'h100, 3);
        ck_req_i = 1; ck_reg_i = 3; tick(); quiet();
        cmp(chk_valid_o, 1'b1, "R2"); cmp(chk_hit_o, 1'b1, "R2"); cmp(stall_o, 1'b0, "R7");

        // R11: check in the insert cycle sees the old table
        ld_req_i = 1; ld_reg_i = 4; ld_addr_i = 'h180; ld_size_i = 0;
        ck_req_i = 1; ck_reg_i = 4;
        tick(); quiet();
        cmp(chk_hit_o, 1'b0, "R11");
        release_stall();
        check(4, 0, 1'b1, "R11");

        // R3: re-insert moves the register's record
        insert(5, 'h200, 0);
        insert(5, 'h300, 0);
        store('h200, 0);
        check(5, 0, 1'b1, "R3");
        store('h300, 0);
        check(5, 0, 1'b0, "R3");

        // R5: clearing check
        insert(6, 'h340, 2);
        check(6, 1, 1'b1, "R5");
        check(6, 0, 1'b0, "R5");

        // R8: store and check together
        insert(7, 'h400, 3);
        st_req_i = 1; st_addr_i = 'h404; st_size_i = 2;
        ck_req_i = 1; ck_reg_i = 7;
        tick(); quiet();
        cmp(chk_hit_o, 1'b0, "R8");
        release_stall();

        // R10: aliasing above the tag and wrap at the top
        insert(8, 'h00500, 2);
        store('h100500, 0);
        check(8, 0, 1'b0, "R10");
        insert(9, 'hFFFFE, 2);
        store('h00001, 0);
        check(9, 0, 1'b0, "R10");
        insert(9, 'hFFFFE, 2);
        store('h00002, 0);
        check(9, 0, 1'b1, "R10");

        // R6: flush with a same-cycle insert
        insert(10, 'h600, 0);
        insert(11, 'h610, 0);
        flush_i = 1; ld_req_i = 1; ld_reg_i = 12; ld_addr_i = 'h620; ld_size_i = 0;
        tick(); quiet();
        check(10, 0, 1'b0, "R6");
        check(11, 0, 1'b0, "R6");
        check(12, 0, 1'b0, "R6");
        insert(13, 'h630, 0);
        flush_i = 1; ck_req_i = 1; ck_reg_i = 13;
        tick(); quiet();
        cmp(chk_hit_o, 1'b0, "R6");
        release_stall();

        // R9: full table, round-robin victims, free slot preferred
        flush();
        for (int r = 20; r < 28; r++) insert(r, 'h1000 + r * 'h10, 3);
        insert(28, 'h1000 + 28 * 'h10, 3);
        check(20, 0, 1'b0, "R9");
        for (int r = 21; r < 29; r++) check(r, 0, 1'b1, "R9");
        insert(29, 'h1000 + 29 * 'h10, 3);
        check(21, 0, 1'b0, "R9");
        check(22, 0, 1'b1, "R9");
        store('h1000 + 23 * 'h10, 0);
        insert(30, 'h1000 + 30 * 'h10, 3);
        check(22, 0, 1'b1, "R9");
        check(24, 0, 1'b1, "R9");
        check(30, 0, 1'b1, "R9");

        // R4: overlap sweep over sizes and offsets
        for (int ls = 0; ls < 4; ls++) begin
            for (int ss = 0; ss < 4; ss++) begin
                for (int off = -12; off <= 12; off++) begin
                    int a, s;
                    logic touch;
                    a = 'h2000;
                    s = a + off;
                    touch = (s < a + (1 << ls)) && (a < s + (1 << ss));
                    flush();
                    insert(1, a, ls);
                    store(s, ss);
                    check(1, 0, !touch, "R4");
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule